// File: doc/BRIEF.md
# Flash Status-Register Overlay Read Path

This block chooses what a word-wide parallel flash model puts on its data pins during a read. There are three possible sources. The first is the main array data. The second is a computed ID/CFI lookup space. The third is a one-word overlay that holds embedded-algorithm status.

A status-read command works as follows:
- It captures the live status on the rising WE# edge that completes the command.
- It switches reads into the overlay. While the overlay is active, the same captured word is returned at every address.
- The first read that completes leaves the overlay, whether it ends through CE# or OE#.
- On exit, the block restores whichever map was selected before the command, either the array or ID/CFI.

Write cycles issued during the overlay are ignored.

All strobes are sampled on `clk`. A strobe edge takes effect on the first clock edge that sees the new level. Read data is a combinational choice based on the registered selection. The array, command sequencing and program/erase algorithms are outside this block. The command decoder presents its decoded operation on `cmd_valid` and `cmd_op`.

Top module: `flash_rd_overlay`

## Requirements
- R1: After reset, the array map is selected, the overlay is inactive, and `dq_oe` is low while CE# or OE# is high.
- R2: A command with `cmd_valid` high and `cmd_op` = 2'b10, seen on a WE# rise while CE# is low, does two things on that clock edge. It captures `status_in`, zero-extended to 16 bits, and it enters the overlay.
- R3: While the overlay is active, a read at any address returns the captured status word.
- R4: The captured word stays constant throughout the overlay. Changes on `status_in` are ignored until the next status-read command.
- R5: The overlay ends on the first clock edge that sees CE# or OE# high after a read in which both were low. Raising either strobe alone is enough.
- R6: Writes of any `cmd_op` issued during the overlay have no effect. They do not end the overlay, do not recapture the status, and do not change the map that will be restored.
- R7: On overlay exit, the map selected when the status-read command was issued becomes active again: the array or ID/CFI.
- R8: Outside the overlay, a command with `cmd_op` = 2'b01 selects the ID/CFI map and 2'b00 selects the array map. A command with 2'b11 changes nothing. Each command takes effect on a WE# rise while CE# is low.
- R9: In the ID/CFI map, only address bits [7:0] are decoded. Word 0x00 returns 0x0001. Words 0x01, 0x0E and 0x0F return the two-byte device codes 0x227E, 0x2228 and 0x2201. Other words in 0x02–0x0D return 0x0000.
- R10: Words 0x10–0x3F form the CFI region, in which the high byte of every word is zero. Word 0x10 returns 0x0051, 0x11 returns 0x0052, 0x12 returns 0x0059, 0x13 returns 0x0002, 0x15 returns 0x0040 and 0x27 returns 0x001B. Every other word returns 0x0000, and so do all words above 0x3F.
- R11: In the array map, `dq_out` equals `array_data`.
- R12: `dq_oe` is high exactly while CE# and OE# are both low, combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Word address |
| cmd_valid | input | 1 | Decoded command present for this write cycle |
| cmd_op | input | 2 | Decoded command: 00 array, 01 ID/CFI, 10 status read, 11 none |
| status_in | input | STAT_W | Live embedded-algorithm status |
| array_data | input | 16 | Word read from the main array |
| dq_out | output | 16 | Read data |
| dq_oe | output | 1 | Data output driven (high-impedance when low) |

## Verification
Map and overlay changes are registered. A command therefore takes effect on the first clock edge after WE# is seen high, and an overlay exit takes effect on the first edge after CE# or OE# is seen high. `dq_out` and `dq_oe` then follow in the same cycle, with no further delay. The bench changes strobes on the falling clock edge and samples outputs on the next falling edge. Each decision has therefore settled exactly one rising edge earlier. Every read is held over one full cycle before it is sampled, and the next action waits for the edge that commits an exit. This lets the checks also confirm that ignored writes and status changes left the overlay word and the restored map unchanged.

// File: rtl/flash_rd_overlay.sv
module flash_rd_overlay #(
  parameter int          ADDR_W    = 16,
  parameter int          STAT_W    = 8,
  parameter logic [15:0] MFR_CODE  = 16'h0001,
  parameter logic [15:0] DEV_ID1   = 16'h227E,
  parameter logic [15:0] DEV_ID2   = 16'h2228,
  parameter logic [15:0] DEV_ID3   = 16'h2201,
  parameter logic [7:0]  SIZE_LOG2 = 8'h1B
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [STAT_W-1:0] status_in,
  input  logic [15:0]       array_data,
  output logic [15:0]       dq_out,
  output logic              dq_oe
);

  localparam logic [1:0] SEL_ARRAY = 2'd0;
  localparam logic [1:0] SEL_ID    = 2'd1;
  localparam logic [1:0] SEL_SR    = 2'd2;
  localparam logic [1:0] OP_ARRAY  = 2'b00;
  localparam logic [1:0] OP_ID     = 2'b01;
  localparam logic [1:0] OP_SRD    = 2'b10;
  localparam int         LUT_W     = (ADDR_W < 8) ? ADDR_W : 8;

  logic        we_q, rd_q, prev_q;
  logic [1:0]  sel_q;
  logic [15:0] sr_q;

  wire        rd_now  = ~ce_n & ~oe_n;
  wire        we_rise = we_n & ~we_q;
  wire        rd_end  = rd_q & ~rd_now;
  wire        cmd_hit = we_rise & ~ce_n & cmd_valid;
  wire        in_ovl  = (sel_q == SEL_SR);
  wire [15:0] stat_ext = 16'(status_in);

  function automatic logic [15:0] id_cfi_word(input logic [7:0] a);
    logic [15:0] w;
    w = 16'h0000;
    if (a < 8'h10) begin
      case (a)
        8'h00:   w = MFR_CODE;
        8'h01:   w = DEV_ID1;
        8'h0E:   w = DEV_ID2;
        8'h0F:   w = DEV_ID3;
        default: w = 16'h0000;
      endcase
    end else if (a < 8'h40) begin
      case (a)
        8'h10:   w[7:0] = 8'h51;
        8'h11:   w[7:0] = 8'h52;
        8'h12:   w[7:0] = 8'h59;
        8'h13:   w[7:0] = 8'h02;
        8'h15:   w[7:0] = 8'h40;
        8'h27:   w[7:0] = SIZE_LOG2;
        default: w[7:0] = 8'h00;
      endcase
    end
    return w;
  endfunction

  logic [7:0] lut_addr;
  always_comb begin
    lut_addr = 8'h00;
    lut_addr[LUT_W-1:0] = addr[LUT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_q   <= 1'b1;
      rd_q   <= 1'b0;
      sel_q  <= SEL_ARRAY;
      prev_q <= 1'b0;
      sr_q   <= 16'h0000;
    end else begin
      we_q <= we_n;
      rd_q <= rd_now;
      if (in_ovl) begin
        if (rd_end) sel_q <= prev_q ? SEL_ID : SEL_ARRAY;
      end else if (cmd_hit) begin
        case (cmd_op)
          OP_ARRAY: sel_q <= SEL_ARRAY;
          OP_ID:    sel_q <= SEL_ID;
          OP_SRD: begin
            prev_q <= (sel_q == SEL_ID);
            sr_q   <= stat_ext;
            sel_q  <= SEL_SR;
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (sel_q)
      SEL_SR:  dq_out = sr_q;
      SEL_ID:  dq_out = id_cfi_word(lut_addr);
      default: dq_out = array_data;
    endcase
  end

  assign dq_oe = rd_now;

endmodule

// File: rtl/flash_rd_overlay_chk.sv
module flash_rd_overlay_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ce_n,
  input logic              oe_n,
  input logic              we_n,
  input logic [ADDR_W-1:0] addr,
  input logic [15:0]       dq_out,
  input logic              dq_oe,
  input logic [1:0]        sel_q,
  input logic              prev_q,
  input logic [15:0]       sr_q
);

  wire ovl     = (sel_q == 2'd2);
  wire rd_open = ~ce_n & ~oe_n;
  wire in_cfi  = (addr[7:0] >= 8'h10) && (addr[7:0] < 8'h40);

  assert_entry_on_we_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovl) |-> ($past(we_n) && !$past(we_n, 2)));

  assert_word_any_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ovl && dq_oe) |-> (dq_out == sr_q));

  assert_word_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ovl && $past(ovl)) |-> $stable(sr_q));

  assert_exit_first_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ovl && $past(rd_open) && !rd_open) |=> !ovl);

  assert_write_no_exit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ovl && !($past(rd_open) && !rd_open)) |=> ovl);

  assert_saved_map_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovl) |-> (prev_q == ($past(sel_q) == 2'd1)));

  assert_restore_map_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ovl) |-> (sel_q == {1'b0, $past(prev_q)}));

  assert_cfi_hi_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_q == 2'd1 && in_cfi && dq_oe) |-> (dq_out[15:8] == 8'h00));

endmodule

bind flash_rd_overlay flash_rd_overlay_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
  .addr(addr), .dq_out(dq_out), .dq_oe(dq_oe),
  .sel_q(sel_q), .prev_q(prev_q), .sr_q(sr_q)
);

// File: tb/flash_rd_overlay_tb_top.sv
module flash_rd_overlay_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [15:0] addr = '0;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd_op = 2'b11;
  logic [7:0]  status_in = '0;
  logic [15:0] array_data = 16'h0000;
  logic [15:0] dq_out;
  logic        dq_oe;
  int          n_run = 0, n_fail = 0;
  logic        done = 1'b0;

  always #10 clk = ~clk;

  flash_rd_overlay dut_i (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .status_in(status_in), .array_data(array_data),
    .dq_out(dq_out), .dq_oe(dq_oe)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] op);
    @(negedge clk); ce_n = 1'b0; we_n = 1'b0; cmd_valid = 1'b1; cmd_op = op;
    @(negedge clk); we_n = 1'b1;
    @(negedge clk); ce_n = 1'b1; cmd_valid = 1'b0; cmd_op = 2'b11;
  endtask

  // end_mode: 0 both strobes, 1 OE# only first, 2 CE# only first
  task automatic rd(input logic [15:0] a, input int end_mode, output logic [15:0] d, output logic oe);
    @(negedge clk); addr = a; ce_n = 1'b0; oe_n = 1'b0;
    @(negedge clk); d = dq_out; oe = dq_oe;
    if (end_mode == 1) oe_n = 1'b1;
    else if (end_mode == 2) ce_n = 1'b1;
    else begin ce_n = 1'b1; oe_n = 1'b1; end
    @(negedge clk); ce_n = 1'b1; oe_n = 1'b1;
  endtask

  task automatic t_reset;
    logic [15:0] d; logic oe;
    @(negedge clk);
    check("R1 dq_oe idle", {15'b0, dq_oe}, 16'h0000);
    array_data = 16'hA5A5;
    rd(16'h0000, 0, d, oe);
    check("R1 array map after reset", d, 16'hA5A5);
    check("R12 dq_oe during read", {15'b0, oe}, 16'h0001);
  endtask

  task automatic t_array;
    logic [15:0] d; logic oe;
    array_data = 16'h1234; rd(16'h0010, 0, d, oe);
    check("R11 array data 1", d, 16'h1234);
    array_data = 16'hFFFF; rd(16'hFFFF, 0, d, oe);
    check("R11 array data 2", d, 16'hFFFF);
  endtask

  task automatic t_oe;
    @(negedge clk); ce_n = 1'b0; oe_n = 1'b1; #1;
    check("R12 CE low OE high", {15'b0, dq_oe}, 16'h0000);
    ce_n = 1'b1; oe_n = 1'b0; #1;
    check("R12 CE high OE low", {15'b0, dq_oe}, 16'h0000);
    ce_n = 1'b0; #1;
    check("R12 both low", {15'b0, dq_oe}, 16'h0001);
    ce_n = 1'b1; oe_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_id_cfi;
    logic [15:0] d; logic oe;
    array_data = 16'h7777;
    wr(2'b01);
    rd(16'h0000, 0, d, oe); check("R9 manufacturer word", d, 16'h0001);
    rd(16'h0001, 0, d, oe); check("R9 device word 1", d, 16'h227E);
    rd(16'h000E, 0, d, oe); check("R9 device word 2", d, 16'h2228);
    rd(16'h000F, 0, d, oe); check("R9 device word 3", d, 16'h2201);
    rd(16'h0005, 0, d, oe); check("R9 unused ID word", d, 16'h0000);
    rd(16'h0010, 0, d, oe); check("R10 Q", d, 16'h0051);
    rd(16'h0011, 0, d, oe); check("R10 R", d, 16'h0052);
    rd(16'h0012, 0, d, oe); check("R10 Y", d, 16'h0059);
    rd(16'h0013, 0, d, oe); check("R10 word 13", d, 16'h0002);
    rd(16'h0015, 0, d, oe); check("R10 word 15", d, 16'h0040);
    rd(16'h0027, 0, d, oe); check("R10 size word", d, 16'h001B);
    rd(16'h0020, 0, d, oe); check("R10 unused CFI word", d, 16'h0000);
    rd(16'h0040, 0, d, oe); check("R10 above CFI", d, 16'h0000);
    rd(16'h0311, 0, d, oe); check("R9 upper bits ignored", d, 16'h0052);
    wr(2'b11);
    rd(16'h0010, 0, d, oe); check("R8 op 11 no effect", d, 16'h0051);
    wr(2'b00);
    rd(16'h0010, 0, d, oe); check("R8 op 00 selects array", d, 16'h7777);
  endtask

  task automatic t_sr_from_array;
    logic [15:0] d; logic oe;
    array_data = 16'h0BAD;
    status_in = 8'h80;
    wr(2'b10);
    status_in = 8'h01;
    @(negedge clk); #1;
    check("R2 overlay entered no read", {15'b0, dq_oe}, 16'h0000);
    rd(16'h1234, 1, d, oe);
    check("R3 R4 status at odd address", d, 16'h0080);
    rd(16'h0000, 0, d, oe);
    check("R5 R7 exit via OE to array", d, 16'h0BAD);
    status_in = 8'hC3;
    wr(2'b10);
    rd(16'h0027, 0, d, oe); check("R2 recapture new status", d, 16'h00C3);
    rd(16'h0027, 0, d, oe); check("R5 single read only", d, 16'h0BAD);
  endtask

  task automatic t_sr_from_id;
    logic [15:0] d; logic oe;
    array_data = 16'h5555;
    wr(2'b01);
    status_in = 8'h3C;
    wr(2'b10);
    status_in = 8'h99;
    wr(2'b00);
    wr(2'b10);
    wr(2'b01);
    rd(16'h0055, 2, d, oe);
    check("R6 writes ignored in overlay", d, 16'h003C);
    rd(16'h0010, 0, d, oe);
    check("R7 exit via CE restores ID", d, 16'h0051);
    wr(2'b00);
    rd(16'h0010, 0, d, oe);
    check("R8 back to array", d, 16'h5555);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_array();
    t_oe();
    t_id_cfi();
    t_sr_from_array();
    t_sr_from_id();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule